// File: doc/BRIEF.md
# Extension-Enable Legality Gate

This block sits beside the instruction decoder and decides, without any clock, whether an instruction must be flagged illegal because the ISA extension it belongs to has been switched off. It takes the raw 32-bit instruction word and an 18-bit enable vector, one bit per mandatory extension, driven by configuration logic. It returns an illegal flag and a small identifier naming the extension whose enable bit governed the decision.

Many checks cannot be made from the major opcode alone. Floating-point loads and stores are split by their width field, fused and plain FP arithmetic by the format field, cache-block operations by the rs2 field, prefetch hints by a zero destination register inside the OR-immediate space, and CSR accesses by a non-zero funct3 inside the SYSTEM space. Base privilege operations (environment call, breakpoint, trap returns, wait-for-interrupt) are never gated. The gate does not enforce that one extension implies another; keeping the vector consistent is the job of configuration software. It also performs no general decoding: an instruction under no gated extension simply reports identifier 0 and no illegality, leaving malformed encodings to the main decoder.

Enable bit positions and identifiers: bit k of the enable vector governs the extension whose identifier is k+1. Bit 0 multiply/divide (id 1), bit 1 atomics (id 2), bit 2 single FP (id 3), bit 3 double FP (id 4), bit 4 compressed (id 5), bit 5 vector (id 6), bit 6 CSR access (id 7), bit 7 instruction-fetch fence (id 8), bit 8 cache-block management (id 9), bit 9 cache-block zero (id 10), bit 10 cache-block prefetch (id 11), bit 11 half-precision FP (id 12), bit 12 conditional zero (id 13). Bits 13 to 17 belong to extensions whose gating happens elsewhere. Identifier 0 means "none".

Top module: `isa_ext_gate`

## Requirements
- R1: Any instruction with bits [1:0] not equal to 2'b11 is attributed to id 5 (compressed), whatever its other bits.
- R2: For opcodes 7'h07 and 7'h27, funct3 (bits [14:12]) selects the id: 3'b010 gives 3, 3'b011 gives 4, 3'b001 gives 12, 3'b000/3'b101/3'b110/3'b111 give 6, and 3'b100 gives 0.
- R3: For opcodes 7'h43, 7'h47, 7'h4B, 7'h4F and 7'h53, the format field bits [26:25] selects the id: 0 gives 3, 1 gives 4, 2 gives 12, 3 gives 0.
- R4: On opcodes 7'h33 and 7'h3B, funct7 (bits [31:25]) equal to 7'h01 gives id 1; on opcode 7'h33, funct7 7'h07 with funct3 3'b101 or 3'b111 gives id 13; any other funct7 on these opcodes gives 0.
- R5: Opcode 7'h2F always gives id 2 and opcode 7'h57 always gives id 6.
- R6: On opcode 7'h0F, funct3 3'b001 gives id 8; funct3 3'b010 with bits [24:20] of 0, 1 or 2 gives id 9 and of 4 gives id 10; every other value of bits [24:20] under funct3 3'b010, and every other funct3, gives 0.
- R7: On opcode 7'h13, funct3 3'b110 with rd (bits [11:7]) equal to 0 gives id 11; with rd non-zero, or any other funct3, it gives 0.
- R8: On opcode 7'h73, funct3 values 1, 2, 3, 5, 6 and 7 give id 7; funct3 0 (ECALL, EBREAK, MRET, SRET, WFI and other privilege operations) and funct3 4 give 0.
- R9: The illegal output is 1 exactly when the id is non-zero and enable bit id-1 is 0; with id 0 it is 0 for every enable vector.
- R10: Enable bits 13 to 17 never change either output, and the id never depends on the enable vector.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| insn | input | 32 | Instruction word under test |
| ext_en | input | 18 | Per-extension enable, 1 means enabled |
| illegal | output | 1 | Instruction belongs to a disabled extension |
| ext_id | output | 5 | Identifier of the governing extension, 0 for none |

## Verification
A wrong attribution inside the case tree shows at the ports immediately, in the same evaluation, as an unexpected identifier and, when the matching enable bit is cleared, as a missing or spurious illegal flag. Because the block holds no state, any fault is visible for exactly the instruction that exercises it, so each shared opcode cell is swept across its full sub-field (funct3, format, rs2, rd) under every single-bit-cleared enable pattern, which separates a wrong identifier from a wrong enable-bit lookup.

// File: rtl/isa_ext_gate.sv
module isa_ext_gate #(
  parameter int EN_W = 18,
  parameter int ID_W = 5
) (
  input  logic [31:0]     insn,
  input  logic [EN_W-1:0] ext_en,
  output logic            illegal,
  output logic [ID_W-1:0] ext_id
);
  localparam logic [ID_W-1:0] X_NONE   = ID_W'(0);
  localparam logic [ID_W-1:0] X_MUL    = ID_W'(1);
  localparam logic [ID_W-1:0] X_ATOM   = ID_W'(2);
  localparam logic [ID_W-1:0] X_FS     = ID_W'(3);
  localparam logic [ID_W-1:0] X_FD     = ID_W'(4);
  localparam logic [ID_W-1:0] X_CMP    = ID_W'(5);
  localparam logic [ID_W-1:0] X_VEC    = ID_W'(6);
  localparam logic [ID_W-1:0] X_CSR    = ID_W'(7);
  localparam logic [ID_W-1:0] X_IFENCE = ID_W'(8);
  localparam logic [ID_W-1:0] X_CBMGT  = ID_W'(9);
  localparam logic [ID_W-1:0] X_CBZERO = ID_W'(10);
  localparam logic [ID_W-1:0] X_PREF   = ID_W'(11);
  localparam logic [ID_W-1:0] X_FH     = ID_W'(12);
  localparam logic [ID_W-1:0] X_CZERO  = ID_W'(13);

  wire [6:0] opc  = insn[6:0];
  wire [2:0] f3   = insn[14:12];
  wire [6:0] f7   = insn[31:25];
  wire [4:0] rdf  = insn[11:7];
  wire [4:0] rs2f = insn[24:20];
  wire [1:0] fmt  = insn[26:25];

  logic [ID_W-1:0] fp_by_fmt;
  always_comb begin
    case (fmt)
      2'd0:    fp_by_fmt = X_FS;
      2'd1:    fp_by_fmt = X_FD;
      2'd2:    fp_by_fmt = X_FH;
      default: fp_by_fmt = X_NONE;
    endcase
  end

  logic [ID_W-1:0] fp_mem_id;
  always_comb begin
    case (f3)
      3'b001:  fp_mem_id = X_FH;
      3'b010:  fp_mem_id = X_FS;
      3'b011:  fp_mem_id = X_FD;
      3'b100:  fp_mem_id = X_NONE;
      default: fp_mem_id = X_VEC;
    endcase
  end

  logic [ID_W-1:0] cbo_id;
  always_comb begin
    case (rs2f)
      5'd0, 5'd1, 5'd2: cbo_id = X_CBMGT;
      5'd4:             cbo_id = X_CBZERO;
      default:          cbo_id = X_NONE;
    endcase
  end

  always_comb begin
    ext_id = X_NONE;
    if (insn[1:0] != 2'b11) begin
      ext_id = X_CMP;
    end else begin
      case (opc)
        7'h07, 7'h27: ext_id = fp_mem_id;
        7'h43, 7'h47, 7'h4B, 7'h4F, 7'h53: ext_id = fp_by_fmt;
        7'h33: begin
          if (f7 == 7'h01) ext_id = X_MUL;
          else if (f7 == 7'h07 && (f3 == 3'b101 || f3 == 3'b111)) ext_id = X_CZERO;
        end
        7'h3B: if (f7 == 7'h01) ext_id = X_MUL;
        7'h2F: ext_id = X_ATOM;
        7'h57: ext_id = X_VEC;
        7'h0F: begin
          if (f3 == 3'b001) ext_id = X_IFENCE;
          else if (f3 == 3'b010) ext_id = cbo_id;
        end
        7'h13: if (f3 == 3'b110 && rdf == 5'd0) ext_id = X_PREF;
        7'h73: if (f3 != 3'b000 && f3 != 3'b100) ext_id = X_CSR;
        default: ext_id = X_NONE;
      endcase
    end
  end

  logic [EN_W:0] en_ext;
  assign en_ext  = {ext_en, 1'b1};
  assign illegal = ~en_ext[ext_id];
endmodule

// File: rtl/isa_ext_gate_chk.sv
module isa_ext_gate_chk #(
  parameter int EN_W = 18,
  parameter int ID_W = 5
) (
  input logic [31:0]     insn,
  input logic [EN_W-1:0] ext_en,
  input logic            illegal,
  input logic [ID_W-1:0] ext_id
);
  logic en_hit;
  always_comb begin
    en_hit = 1'b1;
    for (int k = 0; k < EN_W; k++)
      if (ext_id == ID_W'(k + 1)) en_hit = ext_en[k];
  end

  always_comb begin
    if (ext_id == '0)
      assert_none_never_illegal_R9: assert (!illegal) else $error("R9 none flagged illegal");
    else
      assert_illegal_matches_bit_R9: assert (illegal == !en_hit) else $error("R9 illegal mismatch");
    assert_id_range_R10: assert (ext_id <= ID_W'(13)) else $error("R10 id out of range");
    if (insn[1:0] != 2'b11)
      assert_compressed_id_R1: assert (ext_id == ID_W'(5)) else $error("R1 compressed id");
    if (insn[1:0] == 2'b11 && insn[6:2] == 5'b11100 && insn[14:12] == 3'b000)
      assert_priv_exempt_R8: assert (ext_id == '0 && !illegal) else $error("R8 privilege gated");
    if (insn[1:0] == 2'b11 && insn[6:2] == 5'b00100 && insn[14:12] == 3'b110 && insn[11:7] != 5'd0)
      assert_ori_ungated_R7: assert (ext_id == '0) else $error("R7 ori gated");
  end
endmodule

bind isa_ext_gate isa_ext_gate_chk #(.EN_W(EN_W), .ID_W(ID_W)) u_chk (.*);

// File: tb/isa_ext_gate_test.sv
module isa_ext_gate_test;
  logic        clk = 1'b0;
  logic [31:0] insn = 32'h0000_0013;
  logic [17:0] ext_en = '1;
  logic        illegal;
  logic [4:0]  ext_id;
  int errors = 0;
  int checks = 0;
  int cycles = 0;

  always #4 clk = ~clk;

  isa_ext_gate uut (.insn(insn), .ext_en(ext_en), .illegal(illegal), .ext_id(ext_id));

  function automatic logic [31:0] mk(input logic [6:0] f7, input logic [4:0] rs2,
                                     input logic [4:0] rs1, input logic [2:0] f3,
                                     input logic [4:0] rd, input logic [6:0] op);
    return {f7, rs2, rs1, f3, rd, op};
  endfunction

  task automatic one(input logic [31:0] w, input logic [17:0] en, input int exp_id, input string tag);
    logic exp_ill;
    @(negedge clk);
    insn = w;
    ext_en = en;
    #1;
    exp_ill = (exp_id != 0) && !en[exp_id-1];
    checks++;
    if (ext_id != 5'(exp_id) || illegal != exp_ill) begin
      errors++;
      $display("FAIL %s insn=%h en=%h got id=%0d ill=%0b exp id=%0d ill=%0b",
               tag, w, en, ext_id, illegal, exp_id, exp_ill);
    end
  endtask

  task automatic sweep(input logic [31:0] w, input int exp_id, input string tag);
    one(w, '1, exp_id, tag);
    one(w, '0, exp_id, tag);
    for (int k = 0; k < 18; k++) one(w, ~(18'd1 << k), exp_id, tag);
  endtask

  initial begin : watchdog
    while (cycles < 150000) begin
      @(posedge clk);
      cycles++;
    end
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin : stim
    int id;
    #2;
    checks++;
    if (illegal !== 1'b0 || ext_id !== 5'd0) begin
      errors++;
      $display("FAIL R9 initial addi got id=%0d ill=%0b exp id=0 ill=0", ext_id, illegal);
    end
    // R1 compressed forms
    sweep(32'h0000_0001, 5, "R1");
    sweep(32'h0000_4502, 5, "R1");
    sweep(32'hFFFF_8082, 5, "R1");
    sweep(32'h0000_0000, 5, "R1");
    // R2 FP/vector memory by width
    for (int f = 0; f < 8; f++) begin
      id = (f == 1) ? 12 : (f == 2) ? 3 : (f == 3) ? 4 : (f == 4) ? 0 : 6;
      sweep(mk(7'h00, 5'd3, 5'd1, 3'(f), 5'd2, 7'h07), id, "R2");
      sweep(mk(7'h02, 5'd3, 5'd1, 3'(f), 5'd2, 7'h27), id, "R2");
    end
    // R3 FP arithmetic by format
    for (int o = 0; o < 5; o++) begin
      logic [6:0] op;
      op = (o == 4) ? 7'h53 : 7'(7'h43 + o * 4);
      for (int f = 0; f < 4; f++) begin
        id = (f == 3) ? 0 : (f == 2) ? 12 : f + 3;
        sweep(mk({5'h05, 2'(f)}, 5'd4, 5'd5, 3'd7, 5'd6, op), id, "R3");
      end
    end
    // R4 multiply and conditional zero
    for (int s = 0; s < 4; s++) begin
      logic [6:0] f7;
      f7 = (s == 0) ? 7'h00 : (s == 1) ? 7'h01 : (s == 2) ? 7'h07 : 7'h20;
      for (int f = 0; f < 8; f++) begin
        id = (f7 == 7'h01) ? 1 : (f7 == 7'h07 && (f == 5 || f == 7)) ? 13 : 0;
        sweep(mk(f7, 5'd2, 5'd3, 3'(f), 5'd4, 7'h33), id, "R4");
        sweep(mk(f7, 5'd2, 5'd3, 3'(f), 5'd4, 7'h3B), (f7 == 7'h01) ? 1 : 0, "R4");
      end
    end
    // R5 atomics and vector arithmetic
    sweep(mk(7'h08, 5'd2, 5'd3, 3'd2, 5'd4, 7'h2F), 2, "R5");
    sweep(mk(7'h00, 5'd2, 5'd3, 3'd3, 5'd4, 7'h2F), 2, "R5");
    sweep(mk(7'h01, 5'd2, 5'd3, 3'd0, 5'd4, 7'h57), 6, "R5");
    sweep(mk(7'h40, 5'd2, 5'd3, 3'd7, 5'd4, 7'h57), 6, "R5");
    // R6 MISC-MEM
    sweep(mk(7'h00, 5'd0, 5'd0, 3'd1, 5'd0, 7'h0F), 8, "R6");
    sweep(mk(7'h00, 5'd0, 5'd0, 3'd0, 5'd0, 7'h0F), 0, "R6");
    for (int r = 0; r < 32; r++) begin
      id = (r <= 2) ? 9 : (r == 4) ? 10 : 0;
      sweep(mk(7'h00, 5'(r), 5'd10, 3'd2, 5'd0, 7'h0F), id, "R6");
    end
    // R7 OP-IMM prefetch hint
    for (int f = 0; f < 8; f++) begin
      sweep(mk(7'h00, 5'd3, 5'd1, 3'(f), 5'd0, 7'h13), (f == 6) ? 11 : 0, "R7");
      sweep(mk(7'h00, 5'd3, 5'd1, 3'(f), 5'd9, 7'h13), 0, "R7");
    end
    // R8 SYSTEM
    for (int f = 0; f < 8; f++)
      sweep(mk(7'h18, 5'd0, 5'd1, 3'(f), 5'd2, 7'h73), (f == 0 || f == 4) ? 0 : 7, "R8");
    sweep(32'h0000_0073, 0, "R8");
    sweep(32'h0010_0073, 0, "R8");
    sweep(32'h3020_0073, 0, "R8");
    sweep(32'h1020_0073, 0, "R8");
    sweep(32'h1050_0073, 0, "R8");
    // R9 ungated base opcodes
    sweep(32'h1234_5037, 0, "R9");
    sweep(32'h0000_006F, 0, "R9");
    sweep(mk(7'h00, 5'd2, 5'd1, 3'd0, 5'd8, 7'h63), 0, "R9");
    sweep(mk(7'h00, 5'd2, 5'd1, 3'd2, 5'd8, 7'h03), 0, "R9");
    // R10 upper enable bits have no effect
    for (int k = 13; k < 18; k++) begin
      one(mk(7'h01, 5'd2, 5'd3, 3'd0, 5'd4, 7'h33), 18'd1 << k, 1, "R10");
      one(32'h0000_0013, 18'd1 << k, 0, "R10");
      one(32'h0000_0073, ~(18'd1 << k), 0, "R10");
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule